// File: doc/BRIEF.md
# Two-Channel Soft-Start and Hiccup Protection Controller

This block is the digital sequencing and protection core of a two-output switching regulator. For each output it produces a stepped reference code that climbs from zero to full scale and then stays there. It gates the PWM pulse of every switching cycle, and it decides when an output is regulating and when it has failed. The analog side is seen only as digital inputs: a strobe that marks each switching cycle, a per-channel overcurrent flag, a digitized feedback code per channel and an over-temperature flag.

During the ramp, an overcurrent pulse blanks the following six switching cycles so that the inductor current can decay. An output that is still below its undervoltage level when its ramp ends trips a fault. So does an output that was regulating and then drops below that level. Any such fault stops both channels, turns on both switch-node pulldowns and holds them for a fixed hiccup interval. After that interval each requested channel starts a fresh ramp. An over-temperature flag also stops both channels, and it holds them off until the flag clears.

Top module: `softstart_hiccup_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no start request, both status outputs read off, both reference codes are 0, and pwm_en and pulldown_on are both 0.
- R2: In soft-start the reference code equals k*REF_FULL/RAMP_STEPS, where step k begins at 0 and increases by one every STEP_CYCLES clocks. Once k reaches RAMP_STEPS the code holds at REF_FULL (800 by default) for as long as the channel regulates.
- R3: On the clock after k reaches RAMP_STEPS, a channel whose feedback code is at least UV_LEVEL = REF_FULL*UV_PCT/100 (680 by default) goes to regulating. Otherwise a fault is declared. A channel therefore shows soft-start for RAMP_STEPS*STEP_CYCLES+1 clocks.
- R4: In soft-start, if oc_flag of a channel is high on a pwm_tick clock while that channel's pwm_en is high, pwm_en goes low for the next six pwm_tick periods. It rises again on the clock after the sixth following pwm_tick.
- R5: If no overcurrent pulse is seen, pwm_en stays high through soft-start and regulation. In the regulating state an overcurrent pulse causes no skipping.
- R6: A regulating channel whose feedback code falls below UV_LEVEL declares a fault on the next clock.
- R7: A fault on either channel puts both channels in hiccup on the same clock. While they are in hiccup, both pulldowns are on, both pwm_en bits are 0 and both reference codes are 0.
- R8: Hiccup lasts exactly HICCUP_CYCLES clocks. Each channel then reads off for one clock, and a channel whose start request is still high re-enters soft-start on the following clock.
- R9: While ot_flag is high, both channels read fault from the next clock on, with pulldowns on and pwm_en at 0. On the clock after ot_flag clears they read off, and they restart as in R8.
- R10: The 3-bit status encoding is off=0, soft-start=1, regulating=2, fault=3, hiccup=4. No other value appears.
- R11: Dropping a channel's start request in soft-start or regulation sends that channel alone to off on the next clock, with its pulldown left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 2 | Per-channel start request, bit 0 is channel 0 |
| pwm_tick | input | 1 | One-clock strobe at the start of each switching cycle |
| oc_flag | input | 2 | Overcurrent pulse seen in the cycle that just ended, sampled with pwm_tick |
| ot_flag | input | 1 | Over-temperature level, cleared at the hysteresis point |
| fb0_code | input | REF_W | Digitized feedback of channel 0 |
| fb1_code | input | REF_W | Digitized feedback of channel 1 |
| ref0_code | output | REF_W | Soft-start reference code of channel 0 |
| ref1_code | output | REF_W | Soft-start reference code of channel 1 |
| pwm_en | output | 2 | Per-channel permission to switch in the current cycle |
| pulldown_on | output | 2 | Per-channel switch-node pulldown enable |
| status0 | output | 3 | Channel 0 state code |
| status1 | output | 3 | Channel 1 state code |

## Verification
The properties assume that oc_flag carries meaning only on a pwm_tick clock, and that the feedback codes and ot_flag are clean synchronous levels with no glitches inside a clock. The bench drives every input on the falling clock edge. It raises an overcurrent flag only together with a tick, and it holds the start requests low until the internal reset release has passed. Feedback codes change only between whole clocks, and they are set either at full scale or clearly under the undervoltage level, so that each fault comes from a single intended cause.

// File: rtl/ssh_pkg.sv
package ssh_pkg;
  // Channel state codes, visible on the status ports.
  typedef enum logic [2:0] {
    CH_OFF    = 3'd0,
    CH_SOFT   = 3'd1,
    CH_REG    = 3'd2,
    CH_FAULT  = 3'd3,
    CH_HICCUP = 3'd4
  } ch_state_e;

  // Common supervisor mode shared by both channels.
  typedef enum logic [1:0] {
    SUP_RUN    = 2'd0,
    SUP_HICCUP = 2'd1,
    SUP_HOT    = 2'd2
  } sup_mode_e;
endpackage

// File: rtl/ssh_supervisor.sv
module ssh_supervisor
  import ssh_pkg::*;
#(
  parameter int HICCUP_CYCLES = 50
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trip_any,
  input  logic      ot_flag,
  output sup_mode_e mode,
  output logic      hic_done
);
  localparam int HC_W = $clog2(HICCUP_CYCLES + 1);

  sup_mode_e       mode_q, mode_d;
  logic [HC_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign hic_done = (mode_q == SUP_HICCUP) && (cnt_q == HC_W'(HICCUP_CYCLES - 1));
  assign mode     = mode_q;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (ot_flag) begin
      mode_d = SUP_HOT;
    end else begin
      unique case (mode_q)
        SUP_RUN: begin
          if (trip_any) begin
            mode_d = SUP_HICCUP;
            cnt_d  = '0;
            cnt_en = 1'b1;
          end
        end
        SUP_HICCUP: begin
          if (hic_done) begin
            mode_d = SUP_RUN;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: mode_d = SUP_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SUP_RUN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ssh_oc_skip.sv
module ssh_oc_skip #(
  parameter int SKIP_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic arm,
  input  logic tick,
  input  logic oc,
  output logic gate_open
);
  localparam int SK_W = $clog2(SKIP_CYCLES + 1);

  logic [SK_W-1:0] skip_q, skip_d;
  logic            skip_en;

  always_comb begin
    skip_d  = skip_q;
    skip_en = 1'b0;
    if (!active) begin
      skip_d  = '0;
      skip_en = 1'b1;
    end else if (tick) begin
      skip_en = 1'b1;
      if (skip_q != '0) begin
        skip_d = skip_q - 1'b1;
      end else if (oc && arm) begin
        skip_d = SK_W'(SKIP_CYCLES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
    end else if (skip_en) begin
      skip_q <= skip_d;
    end
  end

  assign gate_open = active && (skip_q == '0);
endmodule

// File: rtl/ssh_channel.sv
module ssh_channel
  import ssh_pkg::*;
#(
  parameter int REF_W       = 10,
  parameter int REF_FULL    = 800,
  parameter int UV_LEVEL    = 680,
  parameter int RAMP_STEPS  = 16,
  parameter int STEP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REF_W-1:0] fb_code,
  input  logic             ot_flag,
  input  sup_mode_e        mode,
  input  logic             hic_done,
  input  logic             trip_any,
  output ch_state_e        state,
  output logic             trip,
  output logic [REF_W-1:0] ref_code
);
  localparam int IDX_W  = $clog2(RAMP_STEPS + 1);
  localparam int TMR_W  = $clog2(STEP_CYCLES + 1);
  localparam int PROD_W = REF_W + IDX_W;

  ch_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             ramp_en;
  logic             ramp_done;
  logic             below_uv;
  logic [PROD_W-1:0] prod;

  assign ramp_done = (idx_q == IDX_W'(RAMP_STEPS));
  assign below_uv  = (fb_code < REF_W'(UV_LEVEL));
  assign trip      = ((state_q == CH_SOFT) && ramp_done && below_uv) ||
                     ((state_q == CH_REG) && below_uv);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tmr_d   = tmr_q;
    if (ot_flag) begin
      state_d = CH_FAULT;
    end else if (mode == SUP_HOT) begin
      state_d = CH_OFF;
    end else if (mode == SUP_HICCUP) begin
      state_d = hic_done ? CH_OFF : CH_HICCUP;
    end else if (trip_any) begin
      state_d = CH_HICCUP;
    end else begin
      unique case (state_q)
        CH_OFF: begin
          if (start) state_d = CH_SOFT;
        end
        CH_SOFT: begin
          if (!start) begin
            state_d = CH_OFF;
          end else if (ramp_done) begin
            state_d = CH_REG;
          end else if (tmr_q == TMR_W'(STEP_CYCLES - 1)) begin
            tmr_d = '0;
            idx_d = idx_q + 1'b1;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
        CH_REG: begin
          if (!start) state_d = CH_OFF;
        end
        default: state_d = CH_OFF;
      endcase
    end
    if (state_d inside {CH_OFF, CH_FAULT, CH_HICCUP}) begin
      idx_d = '0;
      tmr_d = '0;
    end
  end

  assign ramp_en = (state_q == CH_SOFT) || (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_OFF;
      idx_q   <= '0;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ramp_en) begin
        idx_q <= idx_d;
        tmr_q <= tmr_d;
      end
    end
  end

  assign prod     = PROD_W'(idx_q) * PROD_W'(REF_FULL);
  assign ref_code = REF_W'(prod / PROD_W'(RAMP_STEPS));
  assign state    = state_q;
endmodule

// File: rtl/softstart_hiccup_ctrl.sv
module softstart_hiccup_ctrl
  import ssh_pkg::*;
#(
  parameter int REF_W         = 10,
  parameter int REF_FULL      = 800,
  parameter int UV_PCT        = 85,
  parameter int RAMP_STEPS    = 16,
  parameter int STEP_CYCLES   = 4,
  parameter int SKIP_CYCLES   = 6,
  parameter int HICCUP_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       start_req,
  input  logic             pwm_tick,
  input  logic [1:0]       oc_flag,
  input  logic             ot_flag,
  input  logic [REF_W-1:0] fb0_code,
  input  logic [REF_W-1:0] fb1_code,
  output logic [REF_W-1:0] ref0_code,
  output logic [REF_W-1:0] ref1_code,
  output logic [1:0]       pwm_en,
  output logic [1:0]       pulldown_on,
  output logic [2:0]       status0,
  output logic [2:0]       status1
);
  localparam int N_CH     = 2;
  localparam int UV_LEVEL = REF_FULL * UV_PCT / 100;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  ch_state_e        st   [N_CH];
  logic [REF_W-1:0] fb   [N_CH];
  logic [REF_W-1:0] rf   [N_CH];
  logic [N_CH-1:0]  trip;
  logic             trip_any;
  sup_mode_e        mode;
  logic             hic_done;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign fb[0]    = fb0_code;
  assign fb[1]    = fb1_code;
  assign trip_any = |trip;

  ssh_supervisor #(.HICCUP_CYCLES(HICCUP_CYCLES)) u_sup (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .trip_any (trip_any),
    .ot_flag  (ot_flag),
    .mode     (mode),
    .hic_done (hic_done)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic active;

    ssh_channel #(
      .REF_W       (REF_W),
      .REF_FULL    (REF_FULL),
      .UV_LEVEL    (UV_LEVEL),
      .RAMP_STEPS  (RAMP_STEPS),
      .STEP_CYCLES (STEP_CYCLES)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .start    (start_req[g]),
      .fb_code  (fb[g]),
      .ot_flag  (ot_flag),
      .mode     (mode),
      .hic_done (hic_done),
      .trip_any (trip_any),
      .state    (st[g]),
      .trip     (trip[g]),
      .ref_code (rf[g])
    );

    assign active = (st[g] == CH_SOFT) || (st[g] == CH_REG);

    ssh_oc_skip #(.SKIP_CYCLES(SKIP_CYCLES)) u_skip (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .active    (active),
      .arm       (st[g] == CH_SOFT),
      .tick      (pwm_tick),
      .oc        (oc_flag[g]),
      .gate_open (pwm_en[g])
    );

    assign pulldown_on[g] = (st[g] == CH_FAULT) || (st[g] == CH_HICCUP);
  end

  assign ref0_code = rf[0];
  assign ref1_code = rf[1];
  assign status0   = st[0];
  assign status1   = st[1];
endmodule

// File: rtl/ssh_chk.sv
module ssh_chk #(
  parameter int REF_W    = 10,
  parameter int REF_FULL = 800,
  parameter int UV_PCT   = 85
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_tick,
  input logic [1:0]       oc_flag,
  input logic             ot_flag,
  input logic [REF_W-1:0] fb0_code,
  input logic [REF_W-1:0] fb1_code,
  input logic [REF_W-1:0] ref0_code,
  input logic [REF_W-1:0] ref1_code,
  input logic [1:0]       pwm_en,
  input logic [1:0]       pulldown_on,
  input logic [2:0]       status0,
  input logic [2:0]       status1
);
  localparam int UV_LEVEL = REF_FULL * UV_PCT / 100;

  AST_REF_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (status0 == 3'd1 && $past(status0) == 3'd1) |-> ref0_code >= $past(ref0_code)); // R2
  AST_REG_FULL0: assert property (@(posedge clk) disable iff (!rst_n)
    status0 == 3'd2 |-> ref0_code == REF_W'(REF_FULL)); // R3
  AST_REG_FULL1: assert property (@(posedge clk) disable iff (!rst_n)
    status1 == 3'd2 |-> ref1_code == REF_W'(REF_FULL)); // R3
  AST_SKIP_AFTER_OC: assert property (@(posedge clk) disable iff (!rst_n)
    (status0 == 3'd1 && pwm_tick && oc_flag[0] && pwm_en[0] && !ot_flag) |=> !pwm_en[0]); // R4
  AST_REG_UV_TRIP0: assert property (@(posedge clk) disable iff (!rst_n)
    (status0 == 3'd2 && fb0_code < REF_W'(UV_LEVEL) && !ot_flag) |=> status0 == 3'd4); // R6
  AST_REG_UV_TRIP1: assert property (@(posedge clk) disable iff (!rst_n)
    (status1 == 3'd2 && fb1_code < REF_W'(UV_LEVEL) && !ot_flag) |=> status1 == 3'd4); // R6
  AST_COMMON_HICCUP: assert property (@(posedge clk) disable iff (!rst_n)
    (status0 == 3'd4) == (status1 == 3'd4)); // R7
  AST_PULLDOWN_NO_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    pulldown_on != 2'b00 |-> pwm_en == 2'b00); // R7
  AST_HOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> (status0 == 3'd3 && status1 == 3'd3 && pwm_en == 2'b00)); // R9
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status0 <= 3'd4 && status1 <= 3'd4); // R10
endmodule

bind softstart_hiccup_ctrl ssh_chk #(
  .REF_W    (REF_W),
  .REF_FULL (REF_FULL),
  .UV_PCT   (UV_PCT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwm_tick    (pwm_tick),
  .oc_flag     (oc_flag),
  .ot_flag     (ot_flag),
  .fb0_code    (fb0_code),
  .fb1_code    (fb1_code),
  .ref0_code   (ref0_code),
  .ref1_code   (ref1_code),
  .pwm_en      (pwm_en),
  .pulldown_on (pulldown_on),
  .status0     (status0),
  .status1     (status1)
);

// File: tb/softstart_hiccup_ctrl_test.sv
module softstart_hiccup_ctrl_test;
  localparam int REF_W = 10, FULL = 800, UV = 680, STEPS = 16, STEPC = 4;
  localparam int SKIPN = 6, HIC = 50, TICKP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] start_req = 2'b00, oc_flag = 2'b00, pwm_en, pulldown_on;
  logic pwm_tick = 1'b0, ot_flag = 1'b0;
  logic [REF_W-1:0] fb0 = '0, fb1 = '0, ref0, ref1;
  logic [2:0] status0, status1;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  softstart_hiccup_ctrl #(
    .REF_W(REF_W), .REF_FULL(FULL), .UV_PCT(85), .RAMP_STEPS(STEPS),
    .STEP_CYCLES(STEPC), .SKIP_CYCLES(SKIPN), .HICCUP_CYCLES(HIC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pwm_tick(pwm_tick),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .fb0_code(fb0), .fb1_code(fb1),
    .ref0_code(ref0), .ref1_code(ref1), .pwm_en(pwm_en),
    .pulldown_on(pulldown_on), .status0(status0), .status1(status1)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Switching-cycle strobe; an overcurrent request rides on the next tick.
  int tcnt = 0;
  int oc_req[2] = '{0, 0};
  int oc_ack[2] = '{0, 0};
  always @(negedge clk) begin
    pwm_tick <= (tcnt == 0);
    for (int c = 0; c < 2; c++) begin
      oc_flag[c] <= (tcnt == 0) && (oc_req[c] != oc_ack[c]);
      if (tcnt == 0 && oc_req[c] != oc_ack[c]) oc_ack[c] = oc_req[c];
    end
    tcnt = (tcnt == TICKP - 1) ? 0 : tcnt + 1;
  end

  // Behavioural reference model, advanced on every rising edge.
  int m_st[2], m_idx[2], m_tmr[2], m_skip[2], m_mode, m_hc, fbv[2], ns;
  bit m_trip, m_hdone;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_st[c] = 0; m_idx[c] = 0; m_tmr[c] = 0; m_skip[c] = 0;
      end
      m_mode = 0; m_hc = 0;
    end else begin
      fbv[0] = fb0; fbv[1] = fb1;
      m_trip = 0;
      for (int c = 0; c < 2; c++)
        if ((m_st[c] == 1 && m_idx[c] == STEPS && fbv[c] < UV) || (m_st[c] == 2 && fbv[c] < UV))
          m_trip = 1;
      m_hdone = (m_mode == 1 && m_hc == HIC - 1);
      for (int c = 0; c < 2; c++) begin
        if (m_st[c] == 1 || m_st[c] == 2) begin
          if (pwm_tick) begin
            if (m_skip[c] > 0) m_skip[c]--;
            else if (oc_flag[c] && m_st[c] == 1) m_skip[c] = SKIPN;
          end
        end else m_skip[c] = 0;
        ns = m_st[c];
        if (ot_flag) ns = 3;
        else if (m_mode == 2) ns = 0;
        else if (m_mode == 1) ns = m_hdone ? 0 : 4;
        else if (m_trip) ns = 4;
        else if (m_st[c] == 0) ns = start_req[c] ? 1 : 0;
        else if (m_st[c] == 1) begin
          if (!start_req[c]) ns = 0;
          else if (m_idx[c] == STEPS) ns = 2;
          else if (m_tmr[c] == STEPC - 1) begin m_tmr[c] = 0; m_idx[c]++; end
          else m_tmr[c]++;
        end else if (m_st[c] == 2) ns = start_req[c] ? 2 : 0;
        else ns = 0;
        if (ns == 0 || ns >= 3) begin m_idx[c] = 0; m_tmr[c] = 0; end
        m_st[c] = ns;
      end
      if (ot_flag) m_mode = 2;
      else if (m_mode == 0) begin
        if (m_trip) begin m_mode = 1; m_hc = 0; end
      end else if (m_mode == 1) begin
        if (m_hdone) m_mode = 0; else m_hc++;
      end else m_mode = 0;
    end
  end

  // Per-clock comparison, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ref0 vs model", int'(ref0), m_idx[0] * FULL / STEPS);
      chk("R2 ref1 vs model", int'(ref1), m_idx[1] * FULL / STEPS);
      for (int c = 0; c < 2; c++) begin
        chk("R4 pwm_en vs model", int'(pwm_en[c]), int'((m_st[c] == 1 || m_st[c] == 2) && m_skip[c] == 0));
        chk("R7 pulldown vs model", int'(pulldown_on[c]), int'(m_st[c] >= 3));
      end
      chk("R10 status0 vs model", int'(status0), m_st[0]);
      chk("R10 status1 vs model", int'(status1), m_st[1]);
    end
  end

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int n;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status0 in reset", int'(status0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 status0", int'(status0), 0);
    chk("R1 status1", int'(status1), 0);
    chk("R1 ref0", int'(ref0), 0);
    chk("R1 pwm_en", int'(pwm_en), 0);
    chk("R1 pulldown", int'(pulldown_on), 0);

    // Channel 0 ramp with one overcurrent pulse early on.
    fb0 = FULL;
    start_req[0] = 1'b1;
    @(negedge clk);
    chk("R10 soft code", int'(status0), 1);
    chk("R5 pwm open at ramp start", int'(pwm_en[0]), 1);
    oc_req[0]++;
    do @(posedge clk); while (!(pwm_tick && oc_flag[0]));
    @(negedge clk);
    chk("R4 skip begins", int'(pwm_en[0]), 0);
    for (int k = 1; k <= SKIPN; k++) begin
      do @(posedge clk); while (!pwm_tick);
      @(negedge clk);
      chk("R4 skip window", int'(pwm_en[0]), int'(k == SKIPN));
    end
    repeat (80) @(negedge clk);
    chk("R3 channel 0 regulating", int'(status0), 2);
    chk("R2 ref0 at full scale", int'(ref0), FULL);

    // Overcurrent while regulating causes no skip.
    oc_req[0]++;
    for (int k = 0; k < 2 * TICKP + 2; k++) begin
      @(negedge clk);
      chk("R5 no skip in regulation", int'(pwm_en[0]), 1);
    end

    // Channel 1 ramps with low feedback and fails at ramp end.
    fb1 = '0;
    start_req[1] = 1'b1;
    @(negedge clk);
    n = 0;
    while (status1 == 3'd1 && n < 200) begin n++; @(negedge clk); end
    chk("R3 soft-start length", n, STEPS * STEPC + 1);
    chk("R3 failed ramp to hiccup", int'(status1), 4);
    chk("R7 other channel in hiccup", int'(status0), 4);
    chk("R7 both pulldowns", int'(pulldown_on), 3);
    chk("R7 pwm off", int'(pwm_en), 0);
    chk("R7 ref0 cleared", int'(ref0), 0);
    fb1 = FULL;
    n = 0;
    while (status0 == 3'd4 && n < 500) begin n++; @(negedge clk); end
    chk("R8 hiccup length", n, HIC);
    chk("R8 off after hiccup", int'(status0), 0);
    @(negedge clk);
    chk("R8 fresh soft-start", int'(status0), 1);
    repeat (80) @(negedge clk);
    chk("R8 ch0 back in regulation", int'(status0), 2);
    chk("R8 ch1 back in regulation", int'(status1), 2);

    // Undervoltage while regulating.
    fb0 = 10'd600;
    @(negedge clk);
    chk("R6 trip from regulation", int'(status0), 4);
    chk("R7 sibling in hiccup", int'(status1), 4);
    fb0 = FULL;
    repeat (HIC + 80) @(negedge clk);
    chk("R6 recovered", int'(status0), 2);

    // Over-temperature.
    ot_flag = 1'b1;
    @(negedge clk);
    chk("R9 ch0 fault", int'(status0), 3);
    chk("R9 ch1 fault", int'(status1), 3);
    chk("R9 pulldowns", int'(pulldown_on), 3);
    repeat (10) @(negedge clk);
    chk("R9 held while hot", int'(status0), 3);
    ot_flag = 1'b0;
    @(negedge clk);
    chk("R9 off after clear", int'(status0), 0);
    @(negedge clk);
    chk("R9 restart", int'(status0), 1);
    repeat (80) @(negedge clk);

    // Release one request.
    start_req[1] = 1'b0;
    @(negedge clk);
    chk("R11 ch1 off", int'(status1), 0);
    chk("R11 no pulldown", int'(pulldown_on), 0);
    chk("R11 ch0 unaffected", int'(status0), 2);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule